// File: doc/BRIEF.md
# Hardware Resource Lock Bank

A set of independent hardware semaphores reached over a simple 32-bit register bus. Each bank guards one shared resource. A requester claims a bank by writing a word that holds its 3-bit identity in bits [31:29] and a set enable flag in bit 28 to the bank's claim register. It then reads the bank's status register. It owns the resource only when the owner field there matches its own identity; otherwise it writes the claim again.

To give the resource back, the owner writes the same word to the bank's release register. Banks are laid out 12 bytes apart. Bank k has its claim register at 12k, its release register at 12k+4 and its status register at 12k+8. A claim against a bank another requester holds has no effect, and so does a release from anyone but the owner. Software that polls the status register therefore gets mutual exclusion with no atomic bus operation.

Top module: `hw_lock_bank`

## Requirements
- R1: After synchronous reset every bank is free, and every status register reads 0x0000_0000.
- R2: A write with bit 28 set to the claim register of a free bank makes it held by the identity in bits [31:29]. Its status then reads owner in [31:29], bit 28 = 1 and all other bits 0.
- R3: A claim write to a bank that is already held changes neither its owner nor its held flag, even when the identity differs.
- R4: A claim write with bit 28 clear has no effect on the bank.
- R5: A release write with bit 28 set and bits [31:29] equal to the current owner frees the bank, after which its status reads 0.
- R6: A release write with a different identity, with bit 28 clear, or to a free bank has no effect.
- R7: Bank k (0 ≤ k < NUM_BANKS) decodes claim at byte address 12k, release at 12k+4 and status at 12k+8, and a write to one bank never changes another.
- R8: `rdata` is registered. In the cycle after a cycle with `rd_en` high at a status address, it holds that bank's status as it was before any write in that same cycle. In every other cycle it is 0, including after reads of claim, release or unmapped addresses.
- R9: Writes to addresses that are not word aligned, or that lie at or beyond 12·NUM_BANKS, change no bank.
- R10: A bank held by identity 0 reads 0x1000_0000, which is distinct from a free bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data: identity [31:29], enable [28] |
| rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default three banks and an 8-bit address. With those values the unmapped area starting at byte 36 and the top of the address space can both be reached. Every identity value, including 0 and 7, is used against every bank. A behavioural model with one owner and one flag per bank is compared with `rdata` every cycle. This covers directed claim and release races and then a long random mix of claims, releases, reads and stray addresses.

// File: rtl/lkb_pkg.sv
package lkb_pkg;
    localparam int ID_W        = 3;
    localparam int ID_LSB      = 29;
    localparam int EN_BIT      = 28;
    localparam int BANK_STRIDE = 12;
    localparam int OFS_CLAIM   = 0;
    localparam int OFS_FREE    = 4;
    localparam int OFS_STAT    = 8;

    typedef struct packed {
        logic            held;
        logic [ID_W-1:0] owner;
    } bank_state_t;

    typedef struct packed {
        logic            en;
        logic [ID_W-1:0] id;
    } req_word_t;

    function automatic req_word_t split_word(input logic [31:0] w);
        req_word_t r;
        r.en = w[EN_BIT];
        r.id = w[ID_LSB +: ID_W];
        return r;
    endfunction

    function automatic logic [31:0] status_word(input bank_state_t s);
        logic [31:0] w;
        w = '0;
        w[ID_LSB +: ID_W] = s.owner;
        w[EN_BIT]         = s.held;
        return w;
    endfunction
endpackage

// File: rtl/lkb_decode.sv
module lkb_decode
    import lkb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_BANKS-1:0] claim_sel,
    output logic [NUM_BANKS-1:0] free_sel,
    output logic [NUM_BANKS-1:0] stat_sel
);
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_dec
        localparam int BASE = k * BANK_STRIDE;
        assign claim_sel[k] = wr_en && (addr == ADDR_W'(BASE + OFS_CLAIM));
        assign free_sel[k]  = wr_en && (addr == ADDR_W'(BASE + OFS_FREE));
        assign stat_sel[k]  = rd_en && (addr == ADDR_W'(BASE + OFS_STAT));
    end

    // R7: one address reaches at most one register of one bank
    p_one_target_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({claim_sel, free_sel, stat_sel}));
endmodule

// File: rtl/lkb_cell.sv
module lkb_cell
    import lkb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        claim_sel,
    input  logic        free_sel,
    input  req_word_t   req,
    output bank_state_t state
);
    logic do_claim;
    logic do_free;

    always_comb begin
        do_claim = claim_sel && req.en && !state.held;
        do_free  = free_sel && req.en && state.held && (req.id == state.owner);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (do_claim) begin
            state.held  <= 1'b1;
            state.owner <= req.id;
        end else if (do_free) begin
            state <= '0;
        end
    end

    // R2: a valid claim on a free bank records the requester
    p_claim_takes_r2: assert property (@(posedge clk) disable iff (rst)
        (claim_sel && req.en && !state.held) |=> (state.held && state.owner == $past(req.id)));

    // R3 / R6: a held bank keeps its owner unless its owner releases it
    p_keep_owner_r3: assert property (@(posedge clk) disable iff (rst)
        (state.held && !(free_sel && req.en && req.id == state.owner))
        |=> (state.held && $stable(state.owner)));

    // R4: a claim without the enable flag leaves a free bank free
    p_no_enable_r4: assert property (@(posedge clk) disable iff (rst)
        (!state.held && !(claim_sel && req.en)) |=> !state.held);

    // R5: a matching release frees the bank
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (free_sel && req.en && state.held && req.id == state.owner) |=> (state == '0));
endmodule

// File: rtl/lkb_rdmux.sv
module lkb_rdmux
    import lkb_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [NUM_BANKS-1:0] stat_sel,
    input  bank_state_t          states [NUM_BANKS],
    output logic [31:0]          rdata
);
    logic [31:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (stat_sel[k]) sel_word = sel_word | status_word(states[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_en ? sel_word : '0;
    end

    // R8: without a read in the previous cycle the bus returns zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    // R8: only the owner field and the held flag may ever be set
    p_clean_word_r8: assert property (@(posedge clk) disable iff (rst)
        rdata[EN_BIT-1:0] == '0);
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
    import lkb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int SPAN = NUM_BANKS * BANK_STRIDE;

    logic [NUM_BANKS-1:0] claim_sel;
    logic [NUM_BANKS-1:0] free_sel;
    logic [NUM_BANKS-1:0] stat_sel;
    bank_state_t          states [NUM_BANKS];
    req_word_t            req;

    assign req = split_word(wdata);

    lkb_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_decode (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .claim_sel(claim_sel), .free_sel(free_sel), .stat_sel(stat_sel)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_cell
        lkb_cell i_cell (
            .clk(clk), .rst(rst), .claim_sel(claim_sel[k]),
            .free_sel(free_sel[k]), .req(req), .state(states[k])
        );
    end

    lkb_rdmux #(.NUM_BANKS(NUM_BANKS)) i_rdmux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .stat_sel(stat_sel),
        .states(states), .rdata(rdata)
    );

    // R9: a write outside the bank window or off word alignment selects nothing
    p_stray_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(addr) >= SPAN || addr[1:0] != 2'b00))
        |-> (claim_sel == '0 && free_sel == '0));
endmodule

// File: tb/test_hw_lock_bank.sv
module test_hw_lock_bank;
    localparam int NB  = 3;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit       m_held  [NB];
    bit [2:0] m_owner [NB];

    always #5 clk = ~clk;

    hw_lock_bank #(.NUM_BANKS(NB), .ADDR_W(AW)) i_hw_lock_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic bit [31:0] mk(input int id, input bit en);
        return (32'(id) << 29) | (en ? 32'h1000_0000 : 32'h0);
    endfunction

    task automatic cyc(input bit w, input bit r, input int a, input bit [31:0] d,
                       input string tag);
        bit [31:0] exp;
        int b, off;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
        exp = 32'h0;
        b = a / 12; off = a % 12;
        if (r && a < 12*NB && off == 8)
            exp = (32'(m_owner[b]) << 29) | (m_held[b] ? 32'h1000_0000 : 0);
        @(posedge clk);
        if (w && a < 12*NB && (a % 4) == 0 && d[28]) begin
            if (off == 0 && !m_held[b]) begin
                m_held[b] = 1; m_owner[b] = d[31:29];
            end else if (off == 4 && m_held[b] && m_owner[b] == d[31:29]) begin
                m_held[b] = 0; m_owner[b] = 0;
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d rdata=%08h expected=%08h", tag, a, rdata, exp);
        end
    endtask

    task automatic rd_stat(input int b, input string tag);
        cyc(0, 1, 12*b + 8, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        for (int b = 0; b < NB; b++) rd_stat(b, "R1");
        cyc(1, 0, 0, mk(5, 1), "R2");  rd_stat(0, "R2");
        cyc(1, 0, 0, mk(2, 1), "R3");  rd_stat(0, "R3");
        cyc(1, 0, 0, mk(5, 1), "R3");  rd_stat(0, "R3");
        cyc(1, 0, 12, mk(3, 0), "R4"); rd_stat(1, "R4");
        cyc(1, 0, 4, mk(2, 1), "R6");  rd_stat(0, "R6");
        cyc(1, 0, 4, mk(5, 0), "R6");  rd_stat(0, "R6");
        cyc(1, 0, 16, mk(1, 1), "R6"); rd_stat(1, "R6");
        cyc(1, 0, 4, mk(5, 1), "R5");  rd_stat(0, "R5");
        cyc(1, 0, 24, mk(0, 1), "R10"); rd_stat(2, "R10");
        cyc(1, 0, 12, mk(7, 1), "R7"); rd_stat(1, "R7"); rd_stat(2, "R7"); rd_stat(0, "R7");
        cyc(1, 0, 36, mk(4, 1), "R9"); cyc(1, 0, 1, mk(4, 1), "R9");
        cyc(1, 0, 2, mk(4, 1), "R9");  cyc(1, 0, 255, mk(4, 1), "R9");
        rd_stat(0, "R9");
        cyc(0, 1, 12, 0, "R8"); cyc(0, 1, 44, 0, "R8"); cyc(0, 0, 20, 0, "R8");
        cyc(1, 1, 20, mk(7, 1), "R8"); rd_stat(1, "R8");
        for (int i = 0; i < 2000; i++) begin
            int a;
            int pick;
            pick = $urandom_range(0, 9);
            if (pick == 9) a = $urandom_range(0, 255);
            else a = 12 * $urandom_range(0, NB-1) + 4 * $urandom_range(0, 2);
            cyc($urandom_range(0, 1), $urandom_range(0, 1), a,
                mk($urandom_range(0, 7), $urandom_range(0, 3) != 0), "R7");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule